// File: doc/BRIEF.md
# Reaction Timer with Four-Digit Decimal Counter

This block is a stopwatch and reaction-timer core. It keeps a four-digit decimal count, with each digit in BCD, and presents the digits on four 4-bit outputs. A 2-bit mode input chooses what the count does. In stopwatch mode the count advances on every pulse of an external tick-enable, which lets a millisecond time base come from outside. A bump input adds exactly one count in any mode and takes priority over both modes.

In reaction mode, the first clock in which the mode reads reaction after any other mode raises an internal entry pulse. The entry pulse clears a hold-off counter. When that counter reaches its fixed limit, the LED output turns on and ticks start advancing the count. Asserting the halt input freezes the count, so the display keeps the measured reaction time. Only a new entry pulse releases the freeze. An active-high asynchronous reset clears the count, the LED and all internal state.

Top module: `reaction_bcd_timer`

## Requirements
- R1: While rst is high, all four digits read 0 and led reads 0, with no clock edge needed.
- R2: Every digit stays within 0..9. A digit carries into the next higher digit only when every lower digit is 9 at the same time (for example, 0099 becomes 0100).
- R3: A count of 9999 advances to 0000.
- R4: In mode 2'b01, each clock edge with tick high adds one to the count, and an edge with tick low leaves the count unchanged.
- R5: An edge with bump high adds exactly one to the count, whatever the mode, tick and halt inputs are doing.
- R6: An edge at which mode is 2'b10 and the mode sampled at the previous edge was not 2'b10 is an entry. After an entry edge, led is 0. Led rises right after the HOLD_CYCLES-th edge that follows the entry edge.
- R7: Once led is high, it stays high until reset or the next entry edge.
- R8: In mode 2'b10, the count does not advance on a tick while led is 0, or at an entry edge.
- R9: In mode 2'b10, an edge with led high and halt high freezes the count. The count then ignores ticks, even after halt falls, until the next entry edge.
- R10: In modes 2'b00 and 2'b11, ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode | input | 2 | 01 selects stopwatch, 10 selects reaction, 00 and 11 hold the count |
| tick | input | 1 | Single-cycle count enable from an external time base |
| bump | input | 1 | Adds one count; has priority over both modes |
| halt | input | 1 | Freezes the reaction measurement |
| led | output | 1 | High once the hold-off delay has expired |
| d_ones | output | 4 | Least significant BCD digit |
| d_tens | output | 4 | Second BCD digit |
| d_hund | output | 4 | Third BCD digit |
| d_thou | output | 4 | Most significant BCD digit |

## Verification
The digits and led are registered, so the effect of the inputs sampled at an edge appears right after that same edge. The one exception is led, which appears HOLD_CYCLES edges after the entry edge. The driver sets the inputs at the falling edge and queues the values expected after the next rising edge. The monitor checks those values 1 ns after that rising edge, so each comparison falls in the cycle where the result is due. The bench shortens the hold-off to 20 cycles, so it can watch the exact cycle led rises, the freeze, a re-entry and the full rollover to 0000 within a short run.

// File: rtl/reaction_bcd_timer.sv
module reaction_bcd_timer #(
  parameter int HOLD_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic       bump,
  input  logic       halt,
  output logic       led,
  output logic [3:0] d_ones,
  output logic [3:0] d_tens,
  output logic [3:0] d_hund,
  output logic [3:0] d_thou
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [15:0]   cnt;
  logic [1:0]    mode_q;
  logic [CW-1:0] wait_cnt;
  logic          armed, frozen;
  logic          arm, react, advance;

  function automatic logic [15:0] bcd_inc(input logic [15:0] v);
    logic [15:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (v[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = v[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign react   = (mode == 2'b10);
  assign arm     = react && (mode_q != 2'b10);
  assign led     = armed && (wait_cnt == LIMIT);
  assign advance = bump
                 || (mode == 2'b01 && tick)
                 || (react && tick && led && !frozen && !halt && !arm);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt      <= '0;
      mode_q   <= '0;
      wait_cnt <= '0;
      armed    <= 1'b0;
      frozen   <= 1'b0;
    end else begin
      mode_q <= mode;
      if (advance) cnt <= bcd_inc(cnt);
      if (arm) begin
        armed    <= 1'b1;
        wait_cnt <= '0;
        frozen   <= 1'b0;
      end else begin
        if (armed && wait_cnt != LIMIT) wait_cnt <= wait_cnt + 1'b1;
        if (react && halt && led) frozen <= 1'b1;
      end
    end
  end

  assign {d_thou, d_hund, d_tens, d_ones} = cnt;

  p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
    d_ones <= 4'd9 && d_tens <= 4'd9 && d_hund <= 4'd9 && d_thou <= 4'd9);

  p_rollover_r3: assert property (@(posedge clk) disable iff (rst)
    (bump && cnt == 16'h9999) |=> (cnt == 16'h0000));

  p_bump_one_r5: assert property (@(posedge clk) disable iff (rst)
    (bump && d_ones != 4'd9) |=>
      (d_ones == $past(d_ones) + 4'd1) && (cnt[15:4] == $past(cnt[15:4])));

  p_entry_dark_r6: assert property (@(posedge clk) disable iff (rst)
    arm |=> !led);

  p_led_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (led && !arm) |=> led);

  p_wait_still_r8: assert property (@(posedge clk) disable iff (rst)
    (react && !led && !bump) |=> $stable(cnt));

  p_frozen_still_r9: assert property (@(posedge clk) disable iff (rst)
    (react && frozen && !arm && !bump) |=> $stable(cnt));

  p_idle_modes_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b00 || mode == 2'b11) && !bump) |=> $stable(cnt));
endmodule

// File: tb/reaction_bcd_timer_bench.sv
`timescale 1ns/100ps
module reaction_bcd_timer_bench;
  localparam int H = 20;

  typedef struct {
    logic [15:0] digits;
    logic        led;
    string       tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic [1:0] mode = 0;
  logic tick = 0, bump = 0, halt = 0;
  logic led;
  logic [3:0] d_ones, d_tens, d_hund, d_thou;

  int checks = 0, fails = 0;
  exp_t q[$];

  int m_count = 0, m_wait = 0;
  logic [1:0] m_prev = 0;
  bit m_armed = 0, m_frozen = 0;

  always #2.5 clk = ~clk;

  reaction_bcd_timer #(.HOLD_CYCLES(H)) u_reaction_bcd_timer (
    .clk(clk), .rst(rst), .mode(mode), .tick(tick), .bump(bump), .halt(halt),
    .led(led), .d_ones(d_ones), .d_tens(d_tens), .d_hund(d_hund), .d_thou(d_thou));

  function automatic logic [15:0] to_bcd(int n);
    return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(string tag, logic [15:0] got_d, logic got_l,
                       logic [15:0] exp_d, logic exp_l);
    checks++;
    if (got_d !== exp_d || got_l !== exp_l) begin
      fails++;
      $display("FAIL %s: digits=%h led=%b expected digits=%h led=%b",
               tag, got_d, got_l, exp_d, exp_l);
    end
  endtask

  task automatic step(logic [1:0] m, logic t, logic b, logic h, string tag);
    bit arm, led_now;
    exp_t e;
    @(negedge clk);
    mode = m; tick = t; bump = b; halt = h;
    arm = (m == 2'b10) && (m_prev != 2'b10);
    led_now = m_armed && (m_wait == H);
    if (b) m_count = (m_count + 1) % 10000;
    else if (m == 2'b01 && t) m_count = (m_count + 1) % 10000;
    else if (m == 2'b10 && t && led_now && !m_frozen && !h && !arm)
      m_count = (m_count + 1) % 10000;
    if (arm) begin
      m_armed = 1; m_wait = 0; m_frozen = 0;
    end else begin
      if (m_armed && m_wait < H) m_wait++;
      if (m == 2'b10 && h && led_now) m_frozen = 1;
    end
    m_prev = m;
    e.digits = to_bcd(m_count);
    e.led = m_armed && (m_wait == H);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; mode = 0; tick = 0; bump = 0; halt = 0;
    #1;
    check("R1 reset", {d_thou, d_hund, d_tens, d_ones}, led, 16'h0000, 1'b0);
    m_count = 0; m_wait = 0; m_prev = 0; m_armed = 0; m_frozen = 0;
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {d_thou, d_hund, d_tens, d_ones}, led, e.digits, e.led);
      end
    end
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 16; i++) step(2'b01, i[0], 0, 0, "R4 stopwatch tick");
    for (int i = 0; i < 4; i++) step(2'b00, 1, 0, 0, "R10 mode 00 idle");
    for (int i = 0; i < 4; i++) step(2'b11, 1, 0, 0, "R10 mode 11 idle");
    for (int i = 0; i < 3; i++) step(2'b00, 0, 1, 0, "R5 bump in idle");
    step(2'b01, 1, 1, 0, "R5 bump with tick");
    for (int i = 0; i < 100; i++) step(2'b01, 1, 0, 0, "R2 carry chain");
    while (m_count < 9996) step(2'b01, 1, 0, 0, "R2 count up");
    for (int i = 0; i < 6; i++) step(2'b01, 1, 0, 0, "R3 rollover");
    do_reset();
    for (int i = 0; i < H + 6; i++) step(2'b10, 1, 0, 0, "R6 R8 hold-off");
    for (int i = 0; i < 5; i++) step(2'b10, 1, 0, 0, "R7 led held");
    step(2'b10, 1, 0, 1, "R9 halt");
    for (int i = 0; i < 6; i++) step(2'b10, 1, 0, 0, "R9 frozen");
    step(2'b10, 0, 1, 0, "R5 bump while frozen");
    step(2'b01, 0, 0, 0, "R7 leave mode");
    for (int i = 0; i < H + 4; i++) step(2'b10, 1, 0, 0, "R6 re-entry");
    do_reset();
    for (int i = 0; i < 3; i++) step(2'b00, 0, 0, 0, "R1 after reset");
    wait (q.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule